// File: doc/BRIEF.md
# Crossbar Training Trial Sequencer

This block is the digital controller for one training step of an analog weight crossbar. A trial is started with a single-cycle request. The block then drives every row of the array through a fixed sequence of phases and raises a one-cycle completion flag when the sequence ends. Each row takes a three-level enable code. The block also drives the row-line codes used when the array is read in transposed direction, and the two strobes that tell the output converters when to sample.

The forward read is split into two equal halves of opposite polarity. The net drive on every cell is therefore zero and the read leaves the stored weights intact. The transposed read, used for back-propagation, follows the same split rule on the row lines. The write phase multiplies time by voltage: each row is enabled with the sign of its error for a number of cycles equal to the error magnitude times a scale factor. Column values and errors are captured when the trial starts. The analog cells, the converters and the weight arithmetic sit outside this block.

The controller has five states. ST_IDLE waits for start. ST_FWD is the forward read and lasts RD_LEN cycles. ST_BWD is the transposed read; it lasts RD_LEN cycles and is entered only when back-propagation mode was requested. ST_WR is the write window and lasts WR_LEN cycles. ST_DONE is a one-cycle completion state. The transitions are:
- ST_IDLE to ST_FWD when start is high.
- ST_FWD to ST_BWD at the end of the forward read if back-propagation mode is on, otherwise ST_FWD to ST_WR.
- ST_BWD to ST_WR at the end of the transposed read.
- ST_WR to ST_DONE at the end of the write window.
- ST_DONE to ST_IDLE unconditionally.

Top module: `tps_trial_sequencer`

## Requirements
- R1: A start accepted at a clock edge gives RD_LEN forward cycles. In back-propagation mode, RD_LEN transposed cycles follow. Then WR_LEN write cycles follow, then one cycle with done_o high, then idle. The mode is sampled with start.
- R2: Each row's enable code is 2 bits wide, at bits [2n+1:2n] for row n. The codes are 00 off, 01 positive and 10 negative. In the forward phase every row is 01 for the first RD_LEN/2 cycles and 10 for the remaining cycles.
- R3: fwd_sample_o is high only in the first forward cycle.
- R4: In the transposed phase every row enable is 01. Row n's line code, at bits [DW*n+DW-1:DW*n] of row_line_o in two's complement, equals the saturated error of row n during the first RD_LEN/2 cycles and its negation during the rest.
- R5: bwd_sample_o is high only in the first transposed cycle, and never in a trial run without back-propagation mode.
- R6: A row's write pulse starts in the first write cycle and lasts PULSE_SCALE times the saturated error magnitude, in whole cycles. During the pulse the enable is 01 for a positive error and 10 for a negative one. After the pulse the enable is off until the window ends.
- R7: Errors are DW-bit two's complement values at bits [DW*n+DW-1:DW*n] of err_i. A zero error gives no pulse. Magnitudes above ERR_MAX, including the most negative code, are treated as ERR_MAX.
- R8: A pulse that would not fit in the window is clamped to WR_LEN-1 cycles.
- R9: col_drive_o shows the column values captured when start was accepted. Errors are captured at the same edge. Later changes on col_in_i or err_i have no effect on the current trial.
- R10: In idle, in the done cycle and outside pulses, every row enable is off. Outside the transposed phase every line code is zero.
- R11: A start while a trial is running is ignored. done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Trial request, honoured only when idle |
| bp_mode_i | input | 1 | Insert the transposed read phase |
| col_in_i | input | COLS*DW | Column input values |
| err_i | input | ROWS*DW | Signed per-row errors |
| col_drive_o | output | COLS*DW | Captured column values driven to the array |
| row_en_o | output | 2*ROWS | Per-row enable codes |
| row_line_o | output | ROWS*DW | Per-row line codes for the transposed read |
| fwd_sample_o | output | 1 | Forward output sample strobe |
| bwd_sample_o | output | 1 | Transposed output sample strobe |
| done_o | output | 1 | Trial complete, one cycle |

## Verification
The hardest case to reach is the relationship between every possible error code and its pulse: saturation of the most negative code, the zero-error case and clamping, all observed cycle by cycle in one write window. The bench assigns the full range of error codes across the rows of successive trials, so every code is exercised in both modes. A second instance with a doubled scale factor drives the same stimulus into the clamp region. During each trial the bench changes the inputs and asserts start again, to show that neither the captured values nor the sequence are disturbed.

// File: rtl/tps_pkg.sv
package tps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FWD  = 3'd1,
        ST_BWD  = 3'd2,
        ST_WR   = 3'd3,
        ST_DONE = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        EN_OFF = 2'b00,
        EN_POS = 2'b01,
        EN_NEG = 2'b10
    } en_code_e;
endpackage

// File: rtl/tps_phase_ctrl.sv
module tps_phase_ctrl
    import tps_pkg::*;
#(
    parameter int RD_LEN = 4,
    parameter int WR_LEN = 9,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          bp_i,
    output phase_e        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic          accept_o,
    output logic          done_o
);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_LEN - 1);
    localparam logic [CW-1:0] WR_LAST = CW'(WR_LEN - 1);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          bp_q, bp_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bp_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bp_q    <= bp_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        bp_d    = bp_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) begin
                    state_d = ST_FWD;
                    bp_d    = bp_i;
                end
            end
            ST_FWD: begin
                if (cnt_q == RD_LAST) begin
                    state_d = bp_q ? ST_BWD : ST_WR;
                    cnt_d   = '0;
                end
            end
            ST_BWD: begin
                if (cnt_q == RD_LAST) begin
                    state_d = ST_WR;
                    cnt_d   = '0;
                end
            end
            ST_WR: begin
                if (cnt_q == WR_LAST) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        phase_o  = state_q;
        cnt_o    = cnt_q;
        accept_o = (state_q == ST_IDLE) && start_i;
        done_o   = (state_q == ST_DONE);
    end
endmodule

// File: rtl/tps_row_driver.sv
module tps_row_driver
    import tps_pkg::*;
#(
    parameter int DW          = 4,
    parameter int RD_LEN      = 4,
    parameter int WR_LEN      = 9,
    parameter int PULSE_SCALE = 1,
    parameter int ERR_MAX     = 7,
    parameter int CW          = 4
) (
    input  phase_e                phase_i,
    input  logic [CW-1:0]         cnt_i,
    input  logic signed [DW-1:0]  err_i,
    output logic [1:0]            en_o,
    output logic signed [DW-1:0]  line_o
);
    localparam int HALF   = RD_LEN / 2;
    localparam int PW_MAX = WR_LEN - 1;

    int                   mag;
    int                   width;
    logic signed [DW-1:0] ysat;
    logic                 neg;

    always_comb begin
        neg = err_i[DW-1];
        mag = neg ? -int'(err_i) : int'(err_i);
        if (mag > ERR_MAX) mag = ERR_MAX;
        ysat  = neg ? DW'(-mag) : DW'(mag);
        width = mag * PULSE_SCALE;
        if (width > PW_MAX) width = PW_MAX;
    end

    always_comb begin
        en_o   = EN_OFF;
        line_o = '0;
        unique case (phase_i)
            ST_FWD: en_o = (int'(cnt_i) < HALF) ? EN_POS : EN_NEG;
            ST_BWD: begin
                en_o   = EN_POS;
                line_o = (int'(cnt_i) < HALF) ? ysat : -ysat;
            end
            ST_WR: begin
                if (int'(cnt_i) < width) en_o = neg ? EN_NEG : EN_POS;
            end
            default: en_o = EN_OFF;
        endcase
    end
endmodule

// File: rtl/tps_trial_sequencer.sv
module tps_trial_sequencer
    import tps_pkg::*;
#(
    parameter int ROWS        = 4,
    parameter int COLS        = 3,
    parameter int DW          = 4,
    parameter int RD_LEN      = 4,
    parameter int WR_LEN      = 9,
    parameter int PULSE_SCALE = 1,
    parameter int ERR_MAX     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 bp_mode_i,
    input  logic [COLS*DW-1:0]   col_in_i,
    input  logic [ROWS*DW-1:0]   err_i,
    output logic [COLS*DW-1:0]   col_drive_o,
    output logic [2*ROWS-1:0]    row_en_o,
    output logic [ROWS*DW-1:0]   row_line_o,
    output logic                 fwd_sample_o,
    output logic                 bwd_sample_o,
    output logic                 done_o
);
    localparam int LONGEST = (RD_LEN > WR_LEN) ? RD_LEN : WR_LEN;
    localparam int CW      = $clog2(LONGEST + 1);

    phase_e             phase_w;
    logic [CW-1:0]      cnt_w;
    logic               accept_w;
    logic [COLS*DW-1:0] col_q;
    logic [ROWS*DW-1:0] err_q;

    tps_phase_ctrl #(
        .RD_LEN (RD_LEN),
        .WR_LEN (WR_LEN),
        .CW     (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .bp_i     (bp_mode_i),
        .phase_o  (phase_w),
        .cnt_o    (cnt_w),
        .accept_o (accept_w),
        .done_o   (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            err_q <= '0;
        end else if (accept_w) begin
            col_q <= col_in_i;
            err_q <= err_i;
        end
    end

    for (genvar n = 0; n < ROWS; n++) begin : g_row
        tps_row_driver #(
            .DW          (DW),
            .RD_LEN      (RD_LEN),
            .WR_LEN      (WR_LEN),
            .PULSE_SCALE (PULSE_SCALE),
            .ERR_MAX     (ERR_MAX),
            .CW          (CW)
        ) u_row (
            .phase_i (phase_w),
            .cnt_i   (cnt_w),
            .err_i   (err_q[n*DW +: DW]),
            .en_o    (row_en_o[2*n +: 2]),
            .line_o  (row_line_o[n*DW +: DW])
        );
    end

    assign col_drive_o  = col_q;
    assign fwd_sample_o = (phase_w == ST_FWD) && (cnt_w == '0);
    assign bwd_sample_o = (phase_w == ST_BWD) && (cnt_w == '0);
endmodule

// File: rtl/tps_checker.sv
module tps_checker
    import tps_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int XW   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input phase_e            phase,
    input logic              done_o,
    input logic              fwd_sample_o,
    input logic              bwd_sample_o,
    input logic [2*ROWS-1:0] row_en_o,
    input logic [XW-1:0]     col_drive_o
);
    localparam logic [2*ROWS-1:0] ALL_POS = {ROWS{2'b01}};

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(phase) == ST_WR);

    assert_fwd_strobe_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_sample_o |-> row_en_o == ALL_POS);

    assert_bwd_all_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bwd_sample_o |-> row_en_o == ALL_POS);

    assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_sample_o && bwd_sample_o));

    assert_idle_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE || done_o) |-> row_en_o == '0);

    assert_cols_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE) |=> (phase == ST_IDLE || $stable(col_drive_o)));
endmodule

bind tps_trial_sequencer tps_checker #(
    .ROWS (ROWS),
    .XW   (COLS*DW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase_w),
    .done_o       (done_o),
    .fwd_sample_o (fwd_sample_o),
    .bwd_sample_o (bwd_sample_o),
    .row_en_o     (row_en_o),
    .col_drive_o  (col_drive_o)
);

// File: tb/test_tps_trial_sequencer.sv
`timescale 1ns/1ps
module test_tps_trial_sequencer;
    localparam int ROWS = 4;
    localparam int COLS = 3;
    localparam int DW   = 4;
    localparam int RD   = 4;
    localparam int WR   = 9;
    localparam int EMAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bp = 1'b0;
    logic [COLS*DW-1:0] col_in = '0;
    logic [ROWS*DW-1:0] err_in = '0;

    logic [COLS*DW-1:0] col_drv, col_drv_c;
    logic [2*ROWS-1:0]  en, en_c;
    logic [ROWS*DW-1:0] line, line_c;
    logic fs, bs, done, fs_c, bs_c, done_c;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tps_trial_sequencer #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RD_LEN(RD),
        .WR_LEN(WR), .PULSE_SCALE(1), .ERR_MAX(EMAX)) i_tps_trial_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bp_mode_i(bp),
        .col_in_i(col_in), .err_i(err_in), .col_drive_o(col_drv),
        .row_en_o(en), .row_line_o(line), .fwd_sample_o(fs),
        .bwd_sample_o(bs), .done_o(done));

    tps_trial_sequencer #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RD_LEN(RD),
        .WR_LEN(WR), .PULSE_SCALE(2), .ERR_MAX(EMAX)) i_tps_trial_sequencer_clamp (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bp_mode_i(bp),
        .col_in_i(col_in), .err_i(err_in), .col_drive_o(col_drv_c),
        .row_en_o(en_c), .row_line_o(line_c), .fwd_sample_o(fs_c),
        .bwd_sample_o(bs_c), .done_o(done_c));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat_mag(input int e);
        int m = (e < 0) ? -e : e;
        return (m > EMAX) ? EMAX : m;
    endfunction

    function automatic int pulse_w(input int e, input int scale);
        int p = sat_mag(e) * scale;
        return (p > WR - 1) ? WR - 1 : p;
    endfunction

    function automatic logic [2*ROWS-1:0] wr_en(input int e[ROWS], input int c, input int scale);
        logic [2*ROWS-1:0] v = '0;
        for (int r = 0; r < ROWS; r++)
            if (c < pulse_w(e[r], scale)) v[2*r +: 2] = (e[r] < 0) ? 2'b10 : 2'b01;
        return v;
    endfunction

    task automatic run_trial(input int t, input logic bpm);
        int e[ROWS];
        logic [COLS*DW-1:0] x;
        logic [2*ROWS-1:0] exp_en;
        logic [ROWS*DW-1:0] exp_line;
        for (int r = 0; r < ROWS; r++) e[r] = ((t % 4) * 4 + r) - 8;
        x = COLS*DW'(32'h5a3 + t * 32'h111);
        @(negedge clk);
        start = 1'b1; bp = bpm; col_in = x;
        for (int r = 0; r < ROWS; r++) err_in[r*DW +: DW] = DW'(e[r]);
        @(negedge clk);
        // R9 / R11: disturb inputs and repeat start while the trial runs
        col_in = ~x; err_in = ~err_in; bp = ~bpm;
        for (int c = 0; c < RD; c++) begin
            exp_en = (c < RD/2) ? {ROWS{2'b01}} : {ROWS{2'b10}};
            chk("R2 forward enables", en, exp_en);
            chk("R3 forward strobe", fs, c == 0);
            chk("R5 no transposed strobe in forward", bs, 0);
            chk("R10 line zero in forward", line, 0);
            chk("R9 columns held", col_drv, x);
            @(negedge clk);
        end
        start = 1'b0;
        if (bpm) begin
            for (int c = 0; c < RD; c++) begin
                for (int r = 0; r < ROWS; r++) begin
                    int s = (e[r] < 0) ? -sat_mag(e[r]) : sat_mag(e[r]);
                    exp_line[r*DW +: DW] = DW'((c < RD/2) ? s : -s);
                end
                chk("R4 transposed enables", en, {ROWS{2'b01}});
                chk("R4 transposed line codes", line, exp_line);
                chk("R5 transposed strobe", bs, c == 0);
                chk("R3 no forward strobe later", fs, 0);
                @(negedge clk);
            end
        end
        for (int c = 0; c < WR; c++) begin
            chk("R6 R7 write enables", en, wr_en(e, c, 1));
            chk("R8 clamped write enables", en_c, wr_en(e, c, 2));
            chk("R5 R10 write strobes and lines", {bs, fs, line}, 0);
            chk("R1 no done during write", done, 0);
            @(negedge clk);
        end
        chk("R1 done after write", {done, done_c}, 2'b11);
        chk("R10 off in done cycle", en, 0);
        @(negedge clk);
        chk("R11 done single pulse", done, 0);
        chk("R10 idle enables off", en, 0);
        @(negedge clk);
        chk("R11 no restart from stale start", {en, fs}, 0);
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset state", {en, line, fs, bs, done, col_drv}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", {en, fs, bs, done}, 0);
        for (int t = 0; t < 4; t++) run_trial(t, 1'b0);
        for (int t = 0; t < 4; t++) run_trial(t, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule